// File: doc/BRIEF.md
# ADC Digital Output Test Word Generator

This block sits in front of the output serializer of a multi-channel converter. It produces one output word per sample. A 4-bit test code picks the source. With code zero the word is the live converter sample. Any other code puts a known pattern on the word in place of the sample, so that a receiver can prove it captures the data and meets timing.

The patterns come in five kinds:
- fixed words,
- pairs of words that alternate on every sample,
- two words the user programs,
- a short pseudorandom bit stream,
- a long pseudorandom bit stream.

A word-length input selects 14-bit or 12-bit words. A format input selects two's-complement output, which flips the MSB. The flip applies only to the patterns that follow the converter's data format. The word register and all pattern state advance only when the sample strobe is high.

Top module: `adc_test_word_gen`

## Requirements
- R1: With `mode` = 0, each strobed sample loads `live_data` unchanged into `word_out`. The load happens on the clock edge where `sample_en` is high.
- R2: `word_out`, the alternation phase and the PN state change only on a clock edge where `sample_en` is high. On any other edge they hold.
- R3: In 14-bit mode (`wide`=1) the fixed codes produce these words:
  - 1 gives 0x2000.
  - 2 gives 0x3FFF.
  - 3 gives 0x0000.
  - 9 gives 0x2AAA.
  - 10 gives 0x007F.
  - 11 gives 0x2000.
  - 12 gives 0x2867.
- R4: In 12-bit mode (`wide`=0) every code except 0, 5 and 6 places its word in bits 11:0 and drives bits 13:12 to zero. The fixed codes produce these words:
  - 1 gives 0x800.
  - 2 gives 0xFFF.
  - 3 gives 0x000.
  - 9 gives 0xAAA.
  - 10 gives 0x03F.
  - 11 gives 0x800.
  - 12 gives 0xA33.
  - Word 1 of the checkerboard is 0xAAA and word 2 is 0x555.
  - User words take their low 12 bits.
- R5: The alternating codes run word 1, then word 2, and repeat on each strobed sample:
  - Code 4 alternates 0x2AAA and 0x1555.
  - Code 7 alternates all ones and all zeros.
  - Code 8 alternates `user_a` and `user_b`.
  - The first strobed sample under a code different from the code of the previous strobed sample always gives word 1.
- R6: Code 6 outputs 14 consecutive bits per sample from a 9-bit LFSR for x^9+x^5+1. The first bit goes in bit 13.
  - Each step outputs bit 8, then shifts left and inserts bit8 XOR bit4 as the new bit 0.
  - The register reloads all ones on the first strobed sample after entering the code. That sample's word is the first 14 bits from the seed.
  - The word is always 14 bits, whatever `wide` says.
- R7: Code 5 works the same way with a 23-bit LFSR for x^23+x^18+1. Each step outputs bit 22 and inserts bit22 XOR bit17. It is seeded with all ones on entry and is always 14 bits wide.
- R8: With `twos_comp`=1, only codes 1, 2, 3, 5 and 6 have the MSB of the word inverted. That is bit 13 in 14-bit mode and for the PN codes, and bit 11 otherwise. All other codes ignore `twos_comp`.
- R9: Codes 13 to 15 output an all-zero word.
- R10: While `rst_n` is low, `word_out` is zero. The last code is also cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | One pulse per sample; advances the output |
| mode | input | 4 | Test code; 0 selects live data |
| wide | input | 1 | 1 selects 14-bit words, 0 selects 12-bit |
| twos_comp | input | 1 | 1 selects two's-complement output |
| live_data | input | 14 | Converter sample |
| user_a | input | 14 | User word 1 |
| user_b | input | 14 | User word 2 |
| word_out | output | 14 | Output word |

## Verification
Three conditions are the hardest to reach:
- re-entering a PN code after leaving it, which must reseed the register rather than resume;
- switching between two alternating codes while the phase points at word 2, which must restart on word 1;
- changing the code without a strobe and then changing it back, which must count as no change.

The stimulus leaves each PN code partway through a run and returns later. It hops directly between codes 4, 7 and 8 after an odd number of samples. It moves `mode` on cycles where `sample_en` is low. A behavioural model with its own integer LFSRs follows every clock.

// File: rtl/adc_test_word_gen.sv
module adc_test_word_gen #(
  parameter int PN_LONG_LEN  = 23,
  parameter int PN_LONG_TAP  = 18,
  parameter int PN_SHORT_LEN = 9,
  parameter int PN_SHORT_TAP = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_en,
  input  logic [3:0]  mode,
  input  logic        wide,
  input  logic        twos_comp,
  input  logic [13:0] live_data,
  input  logic [13:0] user_a,
  input  logic [13:0] user_b,
  output logic [13:0] word_out
);
  localparam int W = 14;

  logic [3:0]              last_mode;
  logic                    phase;
  logic [PN_LONG_LEN-1:0]  pn_l, pn_l_nxt;
  logic [PN_SHORT_LEN-1:0] pn_s, pn_s_nxt;
  logic [W-1:0]            pn_l_word, pn_s_word;
  logic [W-1:0]            pat14, pat12, pat, flip, nxt;

  wire entering = (mode != last_mode);
  wire second   = !entering && phase;
  wire is_pn    = (mode == 4'd5) || (mode == 4'd6);
  wire fmt_ok   = (mode == 4'd1) || (mode == 4'd2) || (mode == 4'd3) || is_pn;

  always_comb begin
    pn_l_nxt = entering ? '1 : pn_l;
    pn_l_word = '0;
    for (int i = 0; i < W; i++) begin
      pn_l_word[W-1-i] = pn_l_nxt[PN_LONG_LEN-1];
      pn_l_nxt = {pn_l_nxt[PN_LONG_LEN-2:0],
                  pn_l_nxt[PN_LONG_LEN-1] ^ pn_l_nxt[PN_LONG_TAP-1]};
    end
  end

  always_comb begin
    pn_s_nxt = entering ? '1 : pn_s;
    pn_s_word = '0;
    for (int i = 0; i < W; i++) begin
      pn_s_word[W-1-i] = pn_s_nxt[PN_SHORT_LEN-1];
      pn_s_nxt = {pn_s_nxt[PN_SHORT_LEN-2:0],
                  pn_s_nxt[PN_SHORT_LEN-1] ^ pn_s_nxt[PN_SHORT_TAP-1]};
    end
  end

  always_comb begin
    pat14 = '0;
    pat12 = '0;
    unique case (mode)
      4'd1:  begin pat14 = 14'h2000; pat12 = 14'h0800; end
      4'd2:  begin pat14 = 14'h3FFF; pat12 = 14'h0FFF; end
      4'd4:  begin pat14 = second ? 14'h1555 : 14'h2AAA;
                   pat12 = second ? 14'h0555 : 14'h0AAA; end
      4'd7:  begin pat14 = second ? 14'h0000 : 14'h3FFF;
                   pat12 = second ? 14'h0000 : 14'h0FFF; end
      4'd8:  begin pat14 = second ? user_b : user_a;
                   pat12 = {2'b00, pat14[11:0]}; end
      4'd9:  begin pat14 = 14'h2AAA; pat12 = 14'h0AAA; end
      4'd10: begin pat14 = 14'h007F; pat12 = 14'h003F; end
      4'd11: begin pat14 = 14'h2000; pat12 = 14'h0800; end
      4'd12: begin pat14 = 14'h2867; pat12 = 14'h0A33; end
      default: ;
    endcase
  end

  assign pat  = (mode == 4'd5) ? pn_l_word :
                (mode == 4'd6) ? pn_s_word :
                wide ? pat14 : pat12;
  assign flip = (twos_comp && fmt_ok) ? ((wide || is_pn) ? 14'h2000 : 14'h0800) : '0;
  assign nxt  = (mode == 4'd0) ? live_data : (pat ^ flip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_out  <= '0;
      last_mode <= '0;
      phase     <= 1'b0;
      pn_l      <= '1;
      pn_s      <= '1;
    end else if (sample_en) begin
      word_out  <= nxt;
      last_mode <= mode;
      phase     <= !second;
      if (mode == 4'd5) pn_l <= pn_l_nxt;
      if (mode == 4'd6) pn_s <= pn_s_nxt;
    end
  end

  // R1
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && mode == 4'd0 |=> word_out == $past(live_data));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(word_out));

  // R4
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && !wide && mode != 4'd0 && !is_pn |=> word_out[13:12] == 2'b00);

  // R9
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && mode >= 4'd13 |=> word_out == '0);

  // R5
  alt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && wide && mode == 4'd7 && mode != last_mode |=> word_out == 14'h3FFF);
endmodule

// File: tb/sim_adc_test_word_gen.sv
`timescale 1ns/1ps
module sim_adc_test_word_gen;
  logic clk = 0, rst_n = 0, sample_en = 0, wide = 1, twos_comp = 0;
  logic [3:0] mode = 0;
  logic [13:0] live_data = 0, user_a = 14'h1234, user_b = 14'h0ABC;
  logic [13:0] word_out;

  always #2.5 clk = ~clk;

  adc_test_word_gen u0 (.clk, .rst_n, .sample_en, .mode, .wide, .twos_comp,
    .live_data, .user_a, .user_b, .word_out);

  int checks = 0, errors = 0, cycles = 0;
  int m_word = 0, m_last = 0, m_alt = 0;
  int m_long = 32'h7FFFFF, m_short = 32'h1FF;
  string m_req = "R10";

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  function automatic int pn_word(ref int st, input int len, input int tap, input bit fresh);
    int w = 0;
    int msk = (1 << len) - 1;
    if (fresh) st = msk;
    repeat (14) begin
      int top = (st >> (len - 1)) & 1;
      int tp  = (st >> (tap - 1)) & 1;
      w  = w * 2 + top;
      st = ((st << 1) | (top ^ tp)) & msk;
    end
    return w;
  endfunction

  task automatic model();
    int md = mode;
    bit fresh = (md != m_last);
    bit two = !fresh && (m_alt == 1);
    int hi = wide ? 14'h3FFF : 12'hFFF;
    int v = 0;
    bit fmt = 0;
    if (!rst_n) begin
      m_word = 0; m_last = 0; m_alt = 0; m_req = "R10"; return;
    end
    if (!sample_en) begin m_req = "R2"; return; end
    m_req = wide ? "R3" : "R4";
    case (md)
      0: begin v = live_data; m_req = "R1"; end
      1, 11: begin v = wide ? 14'h2000 : 12'h800; fmt = (md == 1); end
      2: begin v = hi; fmt = 1; end
      3: begin v = 0; fmt = 1; end
      4: begin v = two ? (wide ? 14'h1555 : 12'h555) : (wide ? 14'h2AAA : 12'hAAA); m_req = "R5"; end
      7: begin v = two ? 0 : hi; m_req = "R5"; end
      8: begin v = (two ? user_b : user_a) & hi; m_req = "R5"; end
      9: v = wide ? 14'h2AAA : 12'hAAA;
      10: v = wide ? 14'h007F : 12'h03F;
      12: v = wide ? 14'h2867 : 12'hA33;
      5: begin v = pn_word(m_long, 23, 18, fresh); fmt = 1; m_req = "R7"; end
      6: begin v = pn_word(m_short, 9, 5, fresh); fmt = 1; m_req = "R6"; end
      default: begin v = 0; m_req = "R9"; end
    endcase
    if (fmt && twos_comp) begin
      v = v ^ ((wide || md == 5 || md == 6) ? 14'h2000 : 12'h800);
      m_req = "R8";
    end
    m_word = v;
    m_alt = two ? 0 : 1;
    m_last = md;
  endtask

  task automatic tick();
    @(posedge clk);
    model();
    @(negedge clk);
    checks++;
    if (word_out !== m_word[13:0]) begin
      errors++;
      $display("FAIL %s mode=%0d actual=%h expected=%h", m_req, mode, word_out, m_word[13:0]);
    end
  endtask

  task automatic run(input int md, input int n, input bit w, input bit tc, input bit gaps);
    for (int i = 0; i < n; i++) begin
      mode = md[3:0]; wide = w; twos_comp = tc;
      live_data = 14'($urandom);
      sample_en = gaps ? (($urandom % 3) != 0) : 1'b1;
      tick();
    end
  endtask

  initial begin
    @(negedge clk);
    rst_n = 0; sample_en = 1; mode = 4'd2;
    tick(); tick();
    rst_n = 1;
    run(0, 20, 1, 0, 1);
    for (int md = 1; md < 16; md++) begin
      run(md, 6, 1, 0, 0);
      run(md, 6, 0, 0, 0);
      run(md, 6, 1, 1, 1);
      run(md, 6, 0, 1, 0);
    end
    run(4, 3, 1, 0, 0); run(7, 3, 1, 0, 0); run(8, 5, 0, 0, 0); run(4, 1, 1, 0, 0);
    run(8, 7, 1, 0, 1);
    run(5, 30, 1, 0, 0); run(6, 40, 0, 0, 1); run(5, 30, 0, 1, 0); run(6, 600, 1, 0, 0);
    sample_en = 0; mode = 4'd9; tick(); mode = 4'd6; tick();
    run(6, 5, 1, 0, 0);
    sample_en = 0; mode = 4'd7; tick(); tick();
    run(0, 10, 1, 0, 1);
    summary();
  end
endmodule